// File: doc/BRIEF.md
# Coprocessor Access Permission Register and Checker

This block holds a 32-bit system control register that grants or withholds access to a floating-point/SIMD coprocessor pair, numbered 10 and 11. It also decides, for each decoded coprocessor instruction, whether that instruction must trap as undefined. Software reaches the register through a simple read/write port. Only privileged software may use the port. An unprivileged access is refused: it leaves the register unchanged and raises a fault output one cycle later.

The register holds a 2-bit access-right field for each of the two coprocessors, a SIMD-disable bit and a bit that disables the upper sixteen double registers. Two synthesis-time parameters say whether the FPU and the SIMD unit are built in. These parameters decide which bits can be written and which bits are tied to a fixed value.

The checker is combinational from the stored fields, and its result is captured in a register. `chk_undef` is therefore valid one cycle after a check is presented. Where the two rights fields disagree, or hold the reserved encoding, the checker treats access as denied, so the outcome is always deterministic.

Top module: `cpac_top`

## Requirements
- R1: The register layout is fixed.
  - Bit 31 is the SIMD disable bit.
  - Bit 30 is the upper-register (D16-D31) disable bit.
  - Bits [23:22] are the rights for coprocessor 11.
  - Bits [21:20] are the rights for coprocessor 10.
  - All other bits are reserved: they read as zero and ignore writes.
  - With both units present, reading back a privileged write returns wdata & 0xC0F00000.
- R2: Reset is synchronous and active-high. After reset, a read of a full-featured instance returns 0 (both rights fields 00), and `reg_fault` and `chk_undef` are 0.
- R3: Rights 00 (denied) make any check on that coprocessor return undefined, at either privilege.
- R4: Rights 01 (privileged only) make a check with `chk_priv`=0 return undefined. A check with `chk_priv`=1 is allowed.
- R5: Rights 11 (full) allow access at either privilege. The reserved encoding 10 is treated as denied.
- R6: When the coprocessor 11 and coprocessor 10 fields differ, both coprocessors are treated as denied.
- R7: When the SIMD disable bit is 1, every check with `chk_simd`=1 returns undefined. Checks with `chk_simd`=0 are not affected by this bit.
- R8: When the upper-register disable bit is 1, a check with `chk_simd`=0 and `chk_hireg`=1 returns undefined. SIMD checks and low-register checks are not affected by this bit.
- R9: A read or write with `reg_priv`=0 has these effects:
  - `reg_fault` is 1 in the following cycle.
  - The register contents are left unchanged.
  - `reg_rdata` is 0.
  - A privileged access yields `reg_fault`=0.
- R10: Results appear one cycle after their request:
  - `reg_rdata` shows the register one cycle after a privileged read, and is 0 in every other cycle.
  - `chk_undef` is valid one cycle after a check is presented.
  - A check presented in the same cycle as a write uses the old contents. A check presented on the following cycle sees the new contents.
- R11: A check on any coprocessor number other than 10 or 11 returns undefined.
- R12: Build options change how the fields behave:
  - With the FPU present and SIMD absent, bits 31 and 30 read as 1 and ignore writes, so SIMD checks always return undefined.
  - With neither unit present, the rights fields and the disable bits read as zero, and every check returns undefined.
- R13: `chk_undef` is 0 in any cycle that follows a cycle with `chk_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd | input | 1 | Register read request |
| reg_wr | input | 1 | Register write request |
| reg_priv | input | 1 | Requester runs at PL1 or higher |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after a privileged read |
| reg_fault | output | 1 | Unprivileged register access refused |
| chk_valid | input | 1 | A coprocessor instruction is presented for checking |
| chk_cp_num | input | 4 | Coprocessor number of the instruction |
| chk_priv | input | 1 | Instruction executes at PL1 or higher |
| chk_simd | input | 1 | Instruction is a SIMD instruction |
| chk_hireg | input | 1 | Instruction touches D16-D31 |
| chk_undef | output | 1 | Instruction must raise an undefined-instruction exception |

## Verification
Assertions check several rules on every cycle:
- a denied field, a mismatched field pair, an active SIMD disable and an unprivileged check under privileged-only rights always lead to `chk_undef`;
- an idle cycle never leads to `chk_undef`;
- a refused access raises `reg_fault` and leaves the register untouched;
- read data never carries reserved bits.

Only the bench's scenarios can show the rest:
- exact readback values for each build option;
- that full rights let an access through;
- that the upper-register disable spares SIMD instructions;
- the ordering of a write against a check presented in the same cycle.

// File: rtl/cpac_pkg.sv
package cpac_pkg;
  localparam int REG_W       = 32;
  localparam int CP_W        = 4;
  localparam int BIT_SIMD_OFF = 31;
  localparam int BIT_HI_OFF  = 30;
  localparam int RT11_LSB    = 22;
  localparam int RT10_LSB    = 20;
  localparam int CP_FP_A     = 10;
  localparam int CP_FP_B     = 11;

  typedef enum logic [1:0] {
    RT_NONE = 2'b00,
    RT_PRIV = 2'b01,
    RT_RSVD = 2'b10,
    RT_FULL = 2'b11
  } rights_e;
endpackage

// File: rtl/cpac_store.sv
module cpac_store
  import cpac_pkg::*;
#(
  parameter bit HAS_FPU  = 1'b1,
  parameter bit HAS_SIMD = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] view,
  output logic             simd_off,
  output logic             hi_off,
  output rights_e          rt11,
  output rights_e          rt10
);
  localparam bit RIGHTS_LIVE = HAS_FPU || HAS_SIMD;
  localparam bit DIS_LIVE    = HAS_SIMD;
  localparam bit DIS_ONE     = HAS_FPU && !HAS_SIMD;
  localparam logic [REG_W-1:0] RT_MASK  = REG_W'(4'hF) << RT10_LSB;
  localparam logic [REG_W-1:0] DIS_MASK = (REG_W'(1) << BIT_SIMD_OFF) | (REG_W'(1) << BIT_HI_OFF);
  localparam logic [REG_W-1:0] WMASK    = (RIGHTS_LIVE ? RT_MASK : '0) | (DIS_LIVE ? DIS_MASK : '0);
  localparam logic [REG_W-1:0] ONES     = DIS_ONE ? DIS_MASK : '0;

  logic [REG_W-1:0] stored_q;

  always_ff @(posedge clk) begin
    if (rst)        stored_q <= '0;
    else if (wr_en) stored_q <= wdata & WMASK;
  end

  assign view     = (stored_q & WMASK) | ONES;
  assign simd_off = view[BIT_SIMD_OFF];
  assign hi_off   = view[BIT_HI_OFF];
  assign rt11     = rights_e'(view[RT11_LSB +: 2]);
  assign rt10     = rights_e'(view[RT10_LSB +: 2]);

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(view)); // R9
endmodule

// File: rtl/cpac_perm.sv
module cpac_perm
  import cpac_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            chk_valid,
  input  logic [CP_W-1:0] chk_cp_num,
  input  logic            chk_priv,
  input  logic            chk_simd,
  input  logic            chk_hireg,
  input  logic            simd_off,
  input  logic            hi_off,
  input  rights_e         rt11,
  input  rights_e         rt10,
  output logic            chk_undef
);
  localparam logic [CP_W-1:0] CP_A = CP_W'(CP_FP_A);
  localparam logic [CP_W-1:0] CP_B = CP_W'(CP_FP_B);

  logic    is_fp;
  rights_e eff;
  logic    granted;
  logic    undef_c;

  always_comb begin
    is_fp = (chk_cp_num == CP_A) || (chk_cp_num == CP_B);
    eff   = (rt11 == rt10) ? rt10 : RT_NONE;
    case (eff)
      RT_FULL: granted = 1'b1;
      RT_PRIV: granted = chk_priv;
      default: granted = 1'b0;
    endcase
    undef_c = !is_fp || !granted
            || (chk_simd && simd_off)
            || (!chk_simd && chk_hireg && hi_off);
  end

  always_ff @(posedge clk) begin
    if (rst) chk_undef <= 1'b0;
    else     chk_undef <= chk_valid && undef_c;
  end

  AST_DENIED_TRAPS: assert property (@(posedge clk) disable iff (rst)
    chk_valid && rt10 == RT_NONE && (chk_cp_num == CP_A || chk_cp_num == CP_B) |=> chk_undef); // R3
  AST_USER_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    chk_valid && !chk_priv && rt10 == RT_PRIV && rt11 == RT_PRIV |=> chk_undef); // R4
  AST_MISMATCH_DENIED: assert property (@(posedge clk) disable iff (rst)
    chk_valid && rt10 != rt11 |=> chk_undef); // R6
  AST_SIMD_OFF: assert property (@(posedge clk) disable iff (rst)
    chk_valid && chk_simd && simd_off |=> chk_undef); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !chk_undef); // R13
endmodule

// File: rtl/cpac_port.sv
module cpac_port
  import cpac_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic             reg_priv,
  input  logic [REG_W-1:0] view,
  output logic             wr_en,
  output logic [REG_W-1:0] reg_rdata,
  output logic             reg_fault
);
  assign wr_en = reg_wr && reg_priv;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      reg_fault <= 1'b0;
    end else begin
      reg_rdata <= (reg_rd && reg_priv) ? view : '0;
      reg_fault <= (reg_rd || reg_wr) && !reg_priv;
    end
  end

  AST_FAULT_RAISED: assert property (@(posedge clk) disable iff (rst)
    (reg_rd || reg_wr) && !reg_priv |=> reg_fault); // R9
  AST_PRIV_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    reg_priv |=> !reg_fault); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[29:24] == '0 && reg_rdata[19:0] == '0); // R1
endmodule

// File: rtl/cpac_top.sv
module cpac_top
  import cpac_pkg::*;
#(
  parameter bit HAS_FPU  = 1'b1,
  parameter bit HAS_SIMD = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_rd,
  input  logic        reg_wr,
  input  logic        reg_priv,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        reg_fault,
  input  logic        chk_valid,
  input  logic [3:0]  chk_cp_num,
  input  logic        chk_priv,
  input  logic        chk_simd,
  input  logic        chk_hireg,
  output logic        chk_undef
);
  logic [REG_W-1:0] view;
  logic             wr_en;
  logic             simd_off;
  logic             hi_off;
  rights_e          rt11;
  rights_e          rt10;

  cpac_port u_port (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_priv(reg_priv),
    .view(view), .wr_en(wr_en), .reg_rdata(reg_rdata), .reg_fault(reg_fault)
  );

  cpac_store #(.HAS_FPU(HAS_FPU), .HAS_SIMD(HAS_SIMD)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(reg_wdata), .view(view),
    .simd_off(simd_off), .hi_off(hi_off), .rt11(rt11), .rt10(rt10)
  );

  cpac_perm u_perm (
    .clk(clk), .rst(rst), .chk_valid(chk_valid), .chk_cp_num(chk_cp_num),
    .chk_priv(chk_priv), .chk_simd(chk_simd), .chk_hireg(chk_hireg),
    .simd_off(simd_off), .hi_off(hi_off), .rt11(rt11), .rt10(rt10),
    .chk_undef(chk_undef)
  );

  AST_UNPRIV_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    reg_wr && !reg_priv |=> $stable(view)); // R9
endmodule

// File: tb/test_cpac_top.sv
`timescale 1ns/1ps
module test_cpac_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_rd = 1'b0, reg_wr = 1'b0, reg_priv = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        chk_valid = 1'b0, chk_priv = 1'b0, chk_simd = 1'b0, chk_hireg = 1'b0;
  logic [3:0]  chk_cp_num = '0;
  logic [31:0] rdata, rdata_fpu, rdata_bare;
  logic        fault, fault_fpu, fault_bare;
  logic        undef, undef_fpu, undef_bare;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cpac_top i_cpac_top (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_priv(reg_priv),
    .reg_wdata(reg_wdata), .reg_rdata(rdata), .reg_fault(fault),
    .chk_valid(chk_valid), .chk_cp_num(chk_cp_num), .chk_priv(chk_priv),
    .chk_simd(chk_simd), .chk_hireg(chk_hireg), .chk_undef(undef));

  cpac_top #(.HAS_FPU(1'b1), .HAS_SIMD(1'b0)) i_cpac_fpu (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_priv(reg_priv),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_fpu), .reg_fault(fault_fpu),
    .chk_valid(chk_valid), .chk_cp_num(chk_cp_num), .chk_priv(chk_priv),
    .chk_simd(chk_simd), .chk_hireg(chk_hireg), .chk_undef(undef_fpu));

  cpac_top #(.HAS_FPU(1'b0), .HAS_SIMD(1'b0)) i_cpac_bare (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_priv(reg_priv),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_bare), .reg_fault(fault_bare),
    .chk_valid(chk_valid), .chk_cp_num(chk_cp_num), .chk_priv(chk_priv),
    .chk_simd(chk_simd), .chk_hireg(chk_hireg), .chk_undef(undef_bare));

  // {wdata, cp_num, priv, simd, hireg, expected undef}
  localparam int NV = 15;
  localparam logic [39:0] VEC [NV] = '{
    {32'h00F00000, 4'd10, 4'b0000},  // R5 full, user
    {32'h00F00000, 4'd11, 4'b0100},  // R5 full, user SIMD
    {32'h00000000, 4'd10, 4'b1001},  // R3 denied, priv
    {32'h00000000, 4'd11, 4'b0101},  // R3 denied, user
    {32'h00500000, 4'd10, 4'b0001},  // R4 priv-only, user
    {32'h00500000, 4'd11, 4'b1000},  // R4 priv-only, priv
    {32'h00A00000, 4'd10, 4'b1001},  // R5 reserved encoding
    {32'h00D00000, 4'd11, 4'b1001},  // R6 fields differ
    {32'h80F00000, 4'd10, 4'b1101},  // R7 SIMD off, SIMD op
    {32'h80F00000, 4'd10, 4'b0010},  // R7 SIMD off, FP op unaffected
    {32'h40F00000, 4'd11, 4'b1011},  // R8 upper regs off, FP hi
    {32'h40F00000, 4'd10, 4'b0000},  // R8 upper regs off, FP lo
    {32'h40F00000, 4'd11, 4'b0110},  // R8 SIMD hi unaffected
    {32'h00F00000, 4'd9,  4'b1001},  // R11 other coprocessor
    {32'hFFFFFFFF, 4'd10, 4'b1101}   // R1 all ones, R7 SIMD op
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] d, input logic p);
    @(negedge clk);
    reg_wr = 1'b1; reg_priv = p; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_priv = 1'b0;
  endtask

  task automatic do_read(input logic p);
    @(negedge clk);
    reg_rd = 1'b1; reg_priv = p;
    @(negedge clk);
    reg_rd = 1'b0; reg_priv = 1'b0;
  endtask

  task automatic do_check(input logic [3:0] cp, input logic p, input logic s, input logic h);
    @(negedge clk);
    chk_valid = 1'b1; chk_cp_num = cp; chk_priv = p; chk_simd = s; chk_hireg = h;
    @(negedge clk);
    chk_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R2 reset state
    check("R2 fault after reset", 32'(fault), 32'h0);
    check("R2 undef after reset", 32'(undef), 32'h0);
    do_read(1'b1);
    check("R2 reset readback", rdata, 32'h0);
    check("R12 fpu-only reset readback", rdata_fpu, 32'hC0000000);

    // table walk
    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][39:8], 1'b1);
      do_read(1'b1);
      check($sformatf("R1 readback vec %0d", i), rdata, VEC[i][39:8] & 32'hC0F00000);
      do_check(VEC[i][7:4], VEC[i][3], VEC[i][2], VEC[i][1]);
      check($sformatf("R3/R4/R5/R6/R7/R8/R11 undef vec %0d", i), 32'(undef), 32'(VEC[i][0]));
    end

    // R12 build options, register currently all ones
    do_read(1'b1);
    check("R12 fpu-only readback", rdata_fpu, 32'hC0F00000);
    check("R12 bare readback", rdata_bare, 32'h0);
    do_check(4'd10, 1'b1, 1'b1, 1'b0);
    check("R12 fpu-only SIMD traps", 32'(undef_fpu), 32'h1);
    do_check(4'd10, 1'b1, 1'b0, 1'b0);
    check("R12 fpu-only FP lo allowed", 32'(undef_fpu), 32'h0);
    check("R12 bare FP traps", 32'(undef_bare), 32'h1);

    // R9 unprivileged write refused
    do_write(32'h00F00000, 1'b1);
    do_write(32'h00000000, 1'b0);
    check("R9 fault after user write", 32'(fault), 32'h1);
    do_read(1'b1);
    check("R9 contents unchanged", rdata, 32'h00F00000);
    check("R9 no fault on priv read", 32'(fault), 32'h0);
    do_read(1'b0);
    check("R9 fault after user read", 32'(fault), 32'h1);
    check("R9 rdata zero on user read", rdata, 32'h0);
    @(negedge clk);
    check("R10 rdata zero when idle", rdata, 32'h0);

    // R10 check in write cycle sees old contents
    @(negedge clk);
    reg_wr = 1'b1; reg_priv = 1'b1; reg_wdata = 32'h0;
    chk_valid = 1'b1; chk_cp_num = 4'd10; chk_priv = 1'b1; chk_simd = 1'b0; chk_hireg = 1'b0;
    @(negedge clk);
    reg_wr = 1'b0; reg_priv = 1'b0;
    check("R10 same-cycle check uses old value", 32'(undef), 32'h0);
    @(negedge clk);
    chk_valid = 1'b0;
    check("R10 next-cycle check uses new value", 32'(undef), 32'h1);
    @(negedge clk);
    check("R13 idle gives no undef", 32'(undef), 32'h0);

    // R2 reset again clears contents
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    do_read(1'b1);
    check("R2 readback after second reset", rdata, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule